// File: doc/BRIEF.md
# Edge-Triggered Preset Up Counter

This block is an up-counter in the style of a programmable controller. It watches a level input and adds one to a signed accumulator each time that input goes from low to high between two clock edges. A level that stays high counts once. A level that stays low leaves the count alone. The accumulator keeps its value until the synchronous reset clears it.

A done flag compares the live accumulator with a signed preset. The flag is high while the count has reached or gone past the preset. An enable output follows the count input directly. If an increment passes the largest positive value, the accumulator wraps to the most negative value and a sticky overflow flag is raised.

The width is a parameter. With the default of 16 bits the count covers -32768 to +32767.

Top module: `pcnt_up_counter`

## Requirements
- R1: At a rising clock edge where `count_in` is high and the detector's stored level (the value of `count_in` at the previous edge) is low, `acc_out` becomes its old value plus exactly one.
- R2: `acc_out` does not change at any clock edge without such a transition. This holds while `count_in` stays high and while it stays low, so the count is retained when the input drops.
- R3: `done_out` is high exactly when `acc_out` >= `preset_in`, with both read as two's-complement signed numbers. It follows changes of either value combinationally, with no clock delay.
- R4: A clock edge with `rst` high clears `acc_out` to 0, clears `ovf_out` to 0 and sets the detector's stored level to low.
- R5: When `rst` is high at an edge that also sees a low-to-high transition of `count_in`, the reset wins and `acc_out` is 0 after that edge.
- R6: If `count_in` is already high when `rst` is released, the first edge with `rst` low counts one. This happens because the stored level starts out low.
- R7: An increment from the largest positive value (+2^(W-1)-1) yields the most negative value (-2^(W-1)) and sets `ovf_out` at the same edge.
- R8: Once set, `ovf_out` stays high through any further counting and clears only on reset.
- R9: `enable_out` equals the current level of `count_in` at all times.
- R10: `acc_out` and `preset_in` are W bits wide, signed, with W defaulting to 16, which gives the range -32768 to +32767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| count_in | input | 1 | Count condition level |
| preset_in | input | W | Signed preset compared with the accumulator |
| acc_out | output | W | Signed accumulated count |
| enable_out | output | 1 | Mirrors `count_in` |
| done_out | output | 1 | High while accumulator >= preset |
| ovf_out | output | 1 | Sticky wrap indication |

## Verification
The assertions assume three things about the inputs:
- `count_in` and `preset_in` are stable around each rising clock edge. The bench therefore changes inputs only on falling edges.
- A transition of `count_in` counts only if it is seen at a sampled edge. Every stimulus pulse therefore holds high for at least one full clock period.
- The done-monotonicity property assumes the preset stays still across a counting edge. The bench moves the preset only while `count_in` is held low.

The sweep uses a 5-bit accumulator and walks it through every value, including one wrap. At each value it checks every possible preset.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;

    localparam int PCNT_DEF_W = 16;

    typedef enum logic [1:0] {
        ACC_HOLD  = 2'd0,
        ACC_STEP  = 2'd1,
        ACC_CLEAR = 2'd2
    } acc_op_t;

    // Reset outranks a counting transition in the same cycle.
    function automatic acc_op_t pick_op(input logic clr, input logic step);
        if (clr)
            return ACC_CLEAR;
        else if (step)
            return ACC_STEP;
        else
            return ACC_HOLD;
    endfunction

endpackage

// File: rtl/pcnt_edge_detect.sv
module pcnt_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic rise_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= 1'b0;
        else
            prev_q <= level_i;
    end

    assign rise_o = level_i & ~prev_q;

    // R2
    rise_gap_chk: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/pcnt_accum.sv
module pcnt_accum
    import pcnt_pkg::*;
#(
    parameter int W = PCNT_DEF_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                step_i,
    output logic signed [W-1:0] acc_o,
    output logic                ovf_o,
    output logic                at_max_o
);
    localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
    localparam logic signed [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    logic signed [W-1:0] acc_q;
    logic                ovf_q;
    acc_op_t             op;

    assign op       = pick_op(rst, step_i);
    assign at_max_o = (acc_q == MAXV);

    always_ff @(posedge clk) begin
        unique case (op)
            ACC_CLEAR: begin
                acc_q <= '0;
                ovf_q <= 1'b0;
            end
            ACC_STEP: begin
                acc_q <= acc_q + ONE;
                if (at_max_o)
                    ovf_q <= 1'b1;
            end
            default: begin
                acc_q <= acc_q;
                ovf_q <= ovf_q;
            end
        endcase
    end

    assign acc_o = acc_q;
    assign ovf_o = ovf_q;

    // R1
    step_inc_chk: assert property (@(posedge clk) disable iff (rst)
        step_i |=> (acc_q == $past(acc_q) + ONE));

    // R7
    wrap_min_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_q) |-> (acc_q == MINV));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q);

    // R4
    clear_state_chk: assert property (@(posedge clk)
        rst |=> (acc_q == '0 && !ovf_q));

endmodule

// File: rtl/pcnt_compare.sv
module pcnt_compare
    import pcnt_pkg::*;
#(
    parameter int W = PCNT_DEF_W
) (
    input  logic signed [W-1:0] acc_i,
    input  logic signed [W-1:0] preset_i,
    output logic                reached_o
);
    always_comb begin
        reached_o = (acc_i >= preset_i);
    end
endmodule

// File: rtl/pcnt_up_counter.sv
module pcnt_up_counter
    import pcnt_pkg::*;
#(
    parameter int W = PCNT_DEF_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                count_in,
    input  logic signed [W-1:0] preset_in,
    output logic signed [W-1:0] acc_out,
    output logic                enable_out,
    output logic                done_out,
    output logic                ovf_out
);
    logic rise;
    logic at_max;

    pcnt_edge_detect u_edge (
        .clk     (clk),
        .rst     (rst),
        .level_i (count_in),
        .rise_o  (rise)
    );

    pcnt_accum #(.W(W)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .step_i   (rise),
        .acc_o    (acc_out),
        .ovf_o    (ovf_out),
        .at_max_o (at_max)
    );

    pcnt_compare #(.W(W)) u_cmp (
        .acc_i     (acc_out),
        .preset_i  (preset_in),
        .reached_o (done_out)
    );

    assign enable_out = count_in;

    // R2
    hold_no_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !rise |=> $stable(acc_out));

    // R3
    done_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (done_out && rise && !at_max) |=> (done_out || !$stable(preset_in)));

endmodule

// File: tb/sim_pcnt_up_counter.sv
`timescale 1ns/1ps
module sim_pcnt_up_counter;
    localparam int W    = 5;
    localparam int MAXV = (1 << (W-1)) - 1;
    localparam int MINV = -(1 << (W-1));
    localparam int SPAN = 1 << W;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                count_in = 1'b0;
    logic signed [W-1:0] preset_in = '0;
    logic signed [W-1:0] acc_out;
    logic                enable_out, done_out, ovf_out;

    int checks = 0;
    int errors = 0;
    int exp_acc = 0;
    int exp_ovf = 0;

    pcnt_up_counter #(.W(W)) u0 (
        .clk(clk), .rst(rst), .count_in(count_in), .preset_in(preset_in),
        .acc_out(acc_out), .enable_out(enable_out), .done_out(done_out),
        .ovf_out(ovf_out)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_step();
        if (exp_acc == MAXV) begin
            exp_acc = MINV;
            exp_ovf = 1;
        end else begin
            exp_acc = exp_acc + 1;
        end
    endtask

    // One low-to-high transition, held high for a full period.
    task automatic pulse();
        @(negedge clk); count_in = 1'b1;
        @(negedge clk); count_in = 1'b0;
        model_step();
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; count_in = 1'b0;
        @(negedge clk); rst = 1'b0;
        exp_acc = 0; exp_ovf = 0;
        #1;
    endtask

    initial begin
        #(20 * 200000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R4: reset state
        chk("R4 acc", int'(acc_out), 0);
        chk("R4 ovf", int'(ovf_out), 0);
        // R10: signed range, done at preset 0 vs acc 0
        chk("R10 done@0", int'(done_out), 1);

        // R9: enable mirrors the level combinationally
        @(negedge clk); count_in = 1'b1; #1;
        chk("R9 enable high", int'(enable_out), 1);
        @(negedge clk); count_in = 1'b0; #1;
        chk("R9 enable low", int'(enable_out), 0);
        model_step();
        chk("R1 single edge", int'(acc_out), exp_acc);

        // R1/R3/R7: walk every value with every preset
        do_reset();
        for (int s = 0; s <= SPAN; s++) begin
            for (int p = MINV; p <= MAXV; p++) begin
                preset_in = p[W-1:0];
                #1;
                chk("R3 done", int'(done_out), (exp_acc >= p) ? 1 : 0);
            end
            chk("R1 acc", int'(acc_out), exp_acc);
            chk("R7/R8 ovf", int'(ovf_out), exp_ovf);
            pulse();
        end
        chk("R8 sticky after wrap", int'(ovf_out), 1);

        // R2: level held high counts once, held low retains
        preset_in = '0;
        @(negedge clk); count_in = 1'b1;
        @(negedge clk); model_step();
        repeat (5) @(negedge clk);
        #1;
        chk("R2 held high", int'(acc_out), exp_acc);
        count_in = 1'b0;
        repeat (5) @(negedge clk);
        #1;
        chk("R2 retained low", int'(acc_out), exp_acc);

        // R5: reset and edge in the same cycle
        @(negedge clk); count_in = 1'b1; rst = 1'b1;
        @(negedge clk); #1;
        chk("R5 reset wins", int'(acc_out), 0);
        chk("R8 cleared by reset", int'(ovf_out), 0);
        // R6: input still high at release counts once
        rst = 1'b0;
        @(negedge clk); #1;
        chk("R6 first edge after reset", int'(acc_out), 1);
        repeat (3) @(negedge clk);
        #1;
        chk("R6 no repeat", int'(acc_out), 1);
        count_in = 1'b0;

        // R7: wrap once more and check the exact edge
        do_reset();
        repeat (MAXV) pulse();
        chk("R7 at max", int'(acc_out), MAXV);
        chk("R7 no ovf yet", int'(ovf_out), 0);
        pulse();
        chk("R7 wrapped", int'(acc_out), MINV);
        chk("R7 ovf set", int'(ovf_out), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule